// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

A single-clock first-in first-out buffer whose read timing is fixed once per reset. On the first clock edge after reset is released, the block samples a mode-select input and locks it until the next reset. With the input high, the block runs in standard mode. Its two status outputs then act as a "data present" flag and a "space available" flag, and every word, including the first after an empty period, must be requested with an explicit read. With the input low, the block runs in fall-through mode. The same two outputs then act as an output-ready flag and an input-ready flag, and the oldest stored word moves to the data output by itself.

Both modes share one synchronous-read storage array and one output register. In standard mode the output register is loaded only by an accepted read. In fall-through mode the output register is a holding stage: it is refilled from storage whenever it is empty or is being read, so it can hold one word beyond the storage depth. Both flags and the data output are registered.

Top module: `dmf_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, both `avail` and `space` are low after that edge and `rd_data` is zero. On the first edge with `rst` low, `space` goes high and `avail` stays low.
- R2: The mode is the value of `mode_sel` at the first clock edge with `rst` low: 1 selects standard mode and 0 selects fall-through mode.
- R3: Changes on `mode_sel` after that capture edge have no effect until the next reset.
- R4: In standard mode, `avail` is high after an edge exactly when at least one written word has not yet been read.
- R5: In standard mode, `rd_data` changes only on an edge with an accepted read, and it then takes the oldest unread word. Without a read, `rd_data` holds its value even while words are stored.
- R6: In fall-through mode, a word written into an empty FIFO appears on `rd_data` with `avail` high one edge after its write edge, with no read request.
- R7: In fall-through mode, an accepted read loads the next stored word on the same edge and keeps `avail` high. If no word is stored, `avail` drops at that edge. Without a read, `avail` and `rd_data` hold.
- R8: `space` is low when the storage array holds DEPTH (16) words. This is DEPTH words in standard mode and DEPTH+1 in fall-through mode, where the output register holds one more.
- R9: A write happens only on an edge with `wr_en` and `space` both high, and a read only on an edge with `rd_en` and `avail` both high. Other requests change neither the stored contents nor `rd_data`.
- R10: A read and a write accepted on the same edge leave the occupancy unchanged and keep first-in first-out order.
- R11: In standard mode with the FIFO full, a read together with a write request accepts only the read: the written word is dropped and `space` rises after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Mode select sampled once after reset: 1 standard, 0 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered read data |
| avail | output | 1 | Standard: data present. Fall-through: output ready |
| space | output | 1 | Standard: not full. Fall-through: input ready |

## Verification
The standard-mode vector table interleaves writes alone, reads alone, combined read-write, and reads on an empty FIFO. This distinguishes a correct count update from an off-by-one, and it shows that `rd_data` never moves without a read. The same table drives `mode_sel` low after capture, so a block that re-sampled the mode would let a word fall through and be caught. Directed fall-through runs separate first-word latency, holding, and refill-on-read. Fill tests in both modes show the different capacities and the write that is dropped at full.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_FWFT = 1'b0,
    MODE_STD  = 1'b1
  } dmf_mode_t;
endpackage

// File: rtl/dmf_mode_latch.sv
module dmf_mode_latch
  import dmf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  output logic mode_valid,
  output logic mode_std
);
  dmf_mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_valid <= 1'b0;
      mode_q     <= MODE_STD;
    end else if (!mode_valid) begin
      mode_valid <= 1'b1;
      mode_q     <= mode_sel ? MODE_STD : MODE_FWFT;
    end
  end

  assign mode_std = (mode_q == MODE_STD);
endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_valid,
  input  logic          mode_std,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          avail,
  output logic          space,
  output logic          push,
  output logic          load,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_ADR = AW'(DEPTH - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          rd_fire;
  logic          avail_nxt, space_nxt;

  assign push    = wr_en & space;
  assign rd_fire = rd_en & avail;

  always_comb begin
    if (mode_std) load = rd_fire;
    else          load = (cnt != '0) && (!avail || rd_fire);
  end

  always_comb begin
    cnt_nxt = cnt;
    if (push && !load)      cnt_nxt = cnt + 1'b1;
    else if (!push && load) cnt_nxt = cnt - 1'b1;
  end

  always_comb begin
    if (mode_std)     avail_nxt = (cnt_nxt != '0);
    else if (load)    avail_nxt = 1'b1;
    else if (rd_fire) avail_nxt = 1'b0;
    else              avail_nxt = avail;
    space_nxt = mode_valid ? (cnt_nxt != FULL_CNT) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      avail <= 1'b0;
      space <= 1'b0;
      waddr <= '0;
      raddr <= '0;
    end else begin
      cnt   <= cnt_nxt;
      avail <= avail_nxt;
      space <= space_nxt;
      if (push) waddr <= (waddr == LAST_ADR) ? '0 : waddr + 1'b1;
      if (load) raddr <= (raddr == LAST_ADR) ? '0 : raddr + 1'b1;
    end
  end
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             avail,
  output logic             space
);
  logic          mode_valid, mode_std;
  logic          push, load;
  logic [AW-1:0] waddr, raddr;

  dmf_mode_latch i_mode (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .mode_valid(mode_valid), .mode_std(mode_std)
  );

  dmf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .mode_valid(mode_valid), .mode_std(mode_std),
    .wr_en(wr_en), .rd_en(rd_en), .avail(avail), .space(space),
    .push(push), .load(load), .waddr(waddr), .raddr(raddr)
  );

  dmf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ram (
    .clk(clk), .rst(rst), .we(push), .waddr(waddr), .wdata(wr_data),
    .re(load), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk #(
  parameter int WIDTH = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             avail,
  input logic             space,
  input logic             mode_valid,
  input logic             mode_std
);
  logic rst_q;

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_flags_r1: assert (!avail && !space)
        else $error("flags not low after reset edge");
    end
    rst_q <= rst;
  end

  p_space_after_capture_r1: assert property (@(posedge clk) disable iff (rst)
    !mode_valid |=> space);

  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    mode_valid |=> (mode_valid && $stable(mode_std)));

  p_std_empty_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && mode_std && !avail && !wr_en) |=> !avail);

  p_std_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && mode_std && !(rd_en && avail)) |=> $stable(rd_data));

  p_fwft_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && !mode_std && avail && !rd_en) |=> (avail && $stable(rd_data)));

  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && !space && !(rd_en && avail)) |=> !space);
endmodule

bind dmf_fifo dmf_fifo_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .avail(avail), .space(space), .mode_valid(mode_valid), .mode_std(mode_std)
);

// File: tb/test_dmf_fifo.sv
module test_dmf_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 36;
  localparam int DEPTH = 16;
  localparam int NVEC = 13;

  // {rst, mode_sel, wr_en, rd_en, wdata[7:0], exp_avail, exp_space, chk_data, exp_data[7:0]}
  localparam logic [22:0] TBL [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00}, // R1
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00}, // R1
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 1'b0, 1'b1, 1'b1, 8'h00}, // R2 capture std, R9 write ignored
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h21, 1'b1, 1'b1, 1'b1, 8'h00}, // R4, R5 no fall-through
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h22, 1'b1, 1'b1, 1'b1, 8'h00}, // R5
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h21}, // R5 read oldest
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h23, 1'b1, 1'b1, 1'b1, 8'h22}, // R10
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h23}, // R4 empty again
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h23}, // R9 read on empty
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h23}, // R5 hold
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h24, 1'b1, 1'b1, 1'b1, 8'h23}, // R3 still std
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h23}, // R3 no fall-through
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h24}  // R5
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_sel = 1'b1;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             avail, space;
  int               checks = 0;
  int               fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_dmf_fifo (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .avail(avail), .space(space)
  );

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic w, input logic r, input logic [WIDTH-1:0] d);
    wr_en = w; rd_en = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; mode_sel = m; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 avail in reset", 36'(avail), 36'd0);
    chk("R1 space in reset", 36'(space), 36'd0);
    chk("R1 rd_data in reset", rd_data, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 R2 space after capture", 36'(space), 36'd1);
    chk("R1 avail after capture", 36'(avail), 36'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // Table walk: standard mode, R1 R2 R3 R4 R5 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      v = TBL[i];
      rst = v[22]; mode_sel = v[21]; wr_en = v[20]; rd_en = v[19];
      wr_data = 36'(v[18:11]);
      @(negedge clk);
      chk($sformatf("table[%0d] R4 avail", i), 36'(avail), 36'(v[10]));
      chk($sformatf("table[%0d] R8 space", i), 36'(space), 36'(v[9]));
      if (v[8]) chk($sformatf("table[%0d] R5 rd_data", i), rd_data, 36'(v[7:0]));
    end

    // Fall-through mode: R6 R7 R3
    do_reset(1'b0);
    cycle(1'b1, 1'b0, 36'h31);
    chk("R6 avail on write edge", 36'(avail), 36'd0);
    mode_sel = 1'b1;
    cycle(1'b0, 1'b0, 36'h0);
    chk("R6 fell through avail", 36'(avail), 36'd1);
    chk("R6 fell through data", rd_data, 36'h31);
    cycle(1'b1, 1'b0, 36'h32);
    cycle(1'b1, 1'b0, 36'h33);
    chk("R7 R3 hold without read", rd_data, 36'h31);
    cycle(1'b0, 1'b1, 36'h0);
    chk("R7 refill data", rd_data, 36'h32);
    chk("R7 refill avail", 36'(avail), 36'd1);
    cycle(1'b0, 1'b1, 36'h0);
    chk("R7 refill data 2", rd_data, 36'h33);
    cycle(1'b0, 1'b1, 36'h0);
    chk("R7 avail drops", 36'(avail), 36'd0);
    cycle(1'b0, 1'b1, 36'h0);
    chk("R9 read on empty ignored", rd_data, 36'h33);

    // Standard mode fill: R8 R9 R11
    do_reset(1'b1);
    for (int k = 0; k < DEPTH; k++) cycle(1'b1, 1'b0, 36'(8'h40 + k));
    chk("R8 std full", 36'(space), 36'd0);
    chk("R5 std no read yet", rd_data, 36'd0);
    cycle(1'b1, 1'b0, 36'hEE);
    chk("R9 write at full ignored", 36'(space), 36'd0);
    cycle(1'b1, 1'b1, 36'hEF);
    chk("R11 read at full", rd_data, 36'h40);
    chk("R11 space rises", 36'(space), 36'd1);
    for (int k = 1; k < DEPTH; k++) begin
      cycle(1'b0, 1'b1, 36'h0);
      chk($sformatf("R9 R11 drain %0d", k), rd_data, 36'(8'h40 + k));
    end
    chk("R11 dropped word absent", 36'(avail), 36'd0);

    // Fall-through fill: R8
    do_reset(1'b0);
    for (int k = 0; k <= DEPTH; k++) begin
      cycle(1'b1, 1'b0, 36'(8'h50 + k));
      if (k == DEPTH - 1) chk("R8 fwft one short of full", 36'(space), 36'd1);
    end
    chk("R8 fwft full at DEPTH+1", 36'(space), 36'd0);
    chk("R6 fwft head", rd_data, 36'h50);
    cycle(1'b0, 1'b1, 36'h0);
    chk("R7 R8 read frees space", 36'(space), 36'd1);
    chk("R7 next word", rd_data, 36'h51);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule